// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block timestamps transitions on a small set of asynchronous input signals. A shared timebase counts ticks of a prescaled clock while the unit is enabled. Each channel watches one input for the edge polarity chosen in its own two-bit selector. When that edge arrives, the channel copies the current timebase count into its value register and raises a sticky status flag.

Software reads the stored timestamps through a simple word-addressed register port. It takes the difference of two captures to measure an interval. Status flags can be masked into a single interrupt line. They are cleared by writing a mask to an acknowledge register. A global enable bit stops all capture activity and holds the timebase at zero.

Top module: `edge_capture_unit`

## Requirements
- R1: After a synchronous reset, every readable register returns zero and `irq` is low.
- R2: Each channel's selector, read and written at offset 0x30 + 4*channel (bits 1:0), encodes 0 = no capture, 1 = rising edges only, 2 = falling edges only, 3 = both edges; only a selected transition sets that channel's status.
- R3: The timebase advances by exactly one every P+1 clocks, where P is control bits 8:4 at offset 0x50, and wraps to zero after its all-ones value (CNT_W bits).
- R4: On a selected edge the channel's value register (offset 0x10 + 4*channel, zero-extended) takes the timebase count. A later selected edge overwrites it, so two captures D clocks apart differ by D/(P+1) modulo 2^CNT_W when D is a multiple of P+1.
- R5: Channel i's status is bit i+1 of offset 0x58. It stays set until acknowledged, including across later captures.
- R6: A write to offset 0x5C clears each status bit i+1 whose written data bit i+1 is one and leaves the others untouched. A capture in the same cycle as its clear leaves the bit set.
- R7: `irq` goes high one clock after any status bit is set together with its enable bit. Enable bits are bits 4:1 of offset 0x54, laid out like status. `irq` goes low one clock after no such pair remains.
- R8: While control bit 10 is zero no capture occurs and the timebase holds at zero. After enabling, an input rising in the cycle right after the enabling write is stamped with count 2 when P = 0.
- R9: Reads return data one clock after the address is presented. Control reads back only bits 10 and 8:4, and unused bits of every register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| sig_in | input | NCH | Asynchronous inputs to timestamp |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong prescaler phase or counter step shows up as a wrong difference between two captured timestamps. The bench sweeps several prescale settings, and a wrap case, to expose this. A misdecoded selector or status lane shows up as a wrong status bit within five clocks of the transition, so every code is swept against both polarities on every channel. A stuck or wrongly cleared flag is seen at the next status read or on `irq` one clock later.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RISE = 2'd1,
    SEL_FALL = 2'd2,
    SEL_BOTH = 2'd3
  } edge_sel_e;

  localparam int OFS_VAL_BASE = 'h10;
  localparam int OFS_SEL_BASE = 'h30;
  localparam int OFS_CTRL     = 'h50;
  localparam int OFS_IEN      = 'h54;
  localparam int OFS_STAT     = 'h58;
  localparam int OFS_ACK      = 'h5C;
  localparam int CTRL_EN_BIT  = 10;
  localparam int PSC_LSB      = 4;
  localparam int STAT_LSB     = 1;
endpackage

// File: rtl/cap_timebase.sv
module cap_timebase #(
  parameter int CNT_W = 32,
  parameter int PSC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  output logic [CNT_W-1:0] count
);
  logic [PSC_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      div_q <= '0;
      count <= '0;
    end else if (div_q == psc) begin
      div_q <= '0;
      count <= count + CNT_W'(1);
    end else begin
      div_q <= div_q + PSC_W'(1);
    end
  end

  AST_TB_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> (count == '0)); // R8
  AST_TB_STEP: assert property (@(posedge clk) disable iff (rst)
    en |=> ((count - $past(count)) <= CNT_W'(1))); // R3
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             glob_en,
  input  logic             sig,
  input  logic             sel_we,
  input  logic [1:0]       sel_wd,
  input  logic             clr,
  input  logic [CNT_W-1:0] count,
  output logic [1:0]       sel,
  output logic [CNT_W-1:0] value,
  output logic             status
);
  logic s1_q, s2_q, prev_q;
  logic rise, fall, hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= sig;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;
  assign hit  = glob_en & ((sel[0] & rise) | (sel[1] & fall));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel    <= SEL_NONE;
      value  <= '0;
      status <= 1'b0;
    end else begin
      if (sel_we) sel <= sel_wd;
      if (hit) value <= count;
      status <= hit | (status & ~clr);
    end
  end

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (status && !clr) |=> status); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    hit |=> (status && value == $past(count))); // R6
  AST_SEL_NONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE) |=> $stable(value)); // R2
  AST_NO_CAP_OFF: assert property (@(posedge clk) disable iff (rst)
    !glob_en |=> ($stable(value) && (!status || $past(status)))); // R8
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import cap_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NCH-1:0]    sig_in,
  output logic              irq
);
  localparam int STAT_MSB = STAT_LSB + NCH - 1;

  logic             cap_en_q;
  logic [PSC_W-1:0] psc_q;
  logic [NCH-1:0]   ien_q;
  logic [CNT_W-1:0] count;
  logic [NCH-1:0]   status;
  logic [NCH-1:0]   sel_we;
  logic [NCH-1:0]   clr;
  logic [1:0]       sel   [NCH];
  logic [CNT_W-1:0] value [NCH];
  logic [DATA_W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_en_q <= 1'b0;
      psc_q    <= '0;
      ien_q    <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_W'(OFS_CTRL)) begin
        cap_en_q <= reg_wdata[CTRL_EN_BIT];
        psc_q    <= reg_wdata[PSC_LSB +: PSC_W];
      end
      if (reg_addr == ADDR_W'(OFS_IEN))
        ien_q <= reg_wdata[STAT_MSB:STAT_LSB];
    end
  end

  assign clr = (reg_wr && reg_addr == ADDR_W'(OFS_ACK)) ?
               reg_wdata[STAT_MSB:STAT_LSB] : '0;

  cap_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk(clk), .rst(rst), .en(cap_en_q), .psc(psc_q), .count(count)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign sel_we[i] = reg_wr && (reg_addr == ADDR_W'(OFS_SEL_BASE + 4 * i));
    cap_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .glob_en(cap_en_q), .sig(sig_in[i]),
      .sel_we(sel_we[i]), .sel_wd(reg_wdata[1:0]), .clr(clr[i]),
      .count(count), .sel(sel[i]), .value(value[i]), .status(status[i])
    );
  end

  always_comb begin
    rd_next = '0;
    if (reg_addr == ADDR_W'(OFS_CTRL)) begin
      rd_next[CTRL_EN_BIT]       = cap_en_q;
      rd_next[PSC_LSB +: PSC_W]  = psc_q;
    end
    if (reg_addr == ADDR_W'(OFS_IEN))  rd_next[STAT_MSB:STAT_LSB] = ien_q;
    if (reg_addr == ADDR_W'(OFS_STAT)) rd_next[STAT_MSB:STAT_LSB] = status;
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr == ADDR_W'(OFS_VAL_BASE + 4 * i)) rd_next = DATA_W'(value[i]);
      if (reg_addr == ADDR_W'(OFS_SEL_BASE + 4 * i)) rd_next = DATA_W'(sel[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      reg_rdata <= rd_next;
      irq       <= |(status & ien_q);
    end
  end

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|(status & ien_q)) |=> irq); // R7
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    !(|(status & ien_q)) |=> !irq); // R7
  AST_ACK_NO_ENABLE_SET: assert property (@(posedge clk) disable iff (rst)
    !cap_en_q |=> ((status & ~$past(status)) == '0)); // R8
endmodule

// File: tb/tb_edge_capture_unit.sv
`timescale 1ns/1ps
module tb_edge_capture_unit;
  localparam int NCH = 4;
  localparam int CW  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCH-1:0] sig_in = '0;
  logic        irq;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  edge_capture_unit #(.NCH(NCH), .CNT_W(CW), .PSC_W(5), .ADDR_W(8), .DATA_W(32)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sig_in(sig_in), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v, v1, v2;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(8'h50, v); check("R1 ctrl", v, 0);
    rd(8'h54, v); check("R1 ien", v, 0);
    rd(8'h58, v); check("R1 status", v, 0);
    for (int c = 0; c < NCH; c++) begin
      rd(8'(8'h10 + 4 * c), v); check("R1 value", v, 0);
      rd(8'(8'h30 + 4 * c), v); check("R1 sel", v, 0);
    end
    // R9 selector readback, unused bits zero
    for (int c = 0; c < NCH; c++) begin
      wr(8'(8'h30 + 4 * c), 32'hFFFF_FFFC | 32'(c));
      rd(8'(8'h30 + 4 * c), v); check("R9 sel readback", v, 32'(c));
    end
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h50, v); check("R9 ctrl readback", v, 32'h0000_05F0);
    wr(8'h50, 32'h0);
    wr(8'h54, 32'hFFFF_FFFF);
    rd(8'h54, v); check("R9 ien readback", v, 32'h1E);
    wr(8'h54, 32'h0);
    wr(8'h5C, 32'h1FF);
    // R8 absolute stamp right after enabling, P=0
    wr(8'h30, 32'd1);
    wr(8'h50, 32'h400);
    sig_in[0] = 1'b1;
    idle(6);
    rd(8'h10, v); check("R8 first stamp", v, 32'd2);
    rd(8'h58, v); check("R5 status set", v, 32'h2);
    // R2 sweep of every code, polarity and channel
    for (int c = 0; c < NCH; c++) begin
      for (int code = 0; code < 4; code++) begin
        for (int dir = 0; dir < 2; dir++) begin
          wr(8'(8'h30 + 4 * c), 32'(code));
          sig_in[c] = (dir == 0) ? 1'b0 : 1'b1;
          idle(5);
          wr(8'h5C, 32'h1FF);
          @(negedge clk);
          sig_in[c] = ~sig_in[c];
          idle(5);
          rd(8'h58, v);
          check($sformatf("R2 ch%0d code%0d dir%0d", c, code, dir), v,
                (code == 3 || (code == 1 && dir == 0) || (code == 2 && dir == 1))
                ? (32'd1 << (c + 1)) : 32'd0);
        end
      end
    end
    // R3/R4 interval differences over several prescales, including wrap
    foreach (sig_in[c]) wr(8'(8'h30 + 4 * c), 32'd3);
    for (int k = 0; k < 5; k++) begin
      int p, n, d, ch;
      p = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : (k == 3) ? 4 : 31;
      n = (p == 0) ? 300 : 12;
      d = (p + 1) * n;
      ch = k % NCH;
      wr(8'h50, 32'h400 | (32'(p) << 4));
      idle(3);
      wr(8'h5C, 32'h1FF);
      @(negedge clk);
      sig_in[ch] = ~sig_in[ch];
      idle(4);
      rd(8'(8'h10 + 4 * ch), v1);
      idle(d - 6);
      sig_in[ch] = ~sig_in[ch];
      idle(5);
      rd(8'(8'h10 + 4 * ch), v2);
      check($sformatf("R3 R4 diff p=%0d", p), (v2 - v1) & 32'hFF, 32'(n) & 32'hFF);
      rd(8'h58, v); check("R5 sticky after overwrite", v, 32'd1 << (ch + 1));
    end
    // R6 selective acknowledge
    wr(8'h50, 32'h400);
    wr(8'h5C, 32'h1FF);
    foreach (sig_in[c]) wr(8'(8'h30 + 4 * c), 32'd1);
    sig_in = '0;
    idle(5);
    wr(8'h5C, 32'h1FF);
    @(negedge clk);
    sig_in = 4'b0101;
    idle(5);
    rd(8'h58, v); check("R6 two set", v, 32'h0A);
    wr(8'h5C, 32'h04);
    rd(8'h58, v); check("R6 clear unset bit", v, 32'h0A);
    wr(8'h5C, 32'h02);
    rd(8'h58, v); check("R6 clear ch0", v, 32'h08);
    wr(8'h5C, 32'h1FF);
    rd(8'h58, v); check("R6 clear all", v, 32'h0);
    // R7 interrupt
    wr(8'h54, 32'h08);
    sig_in[1] = 1'b1;
    idle(5);
    check("R7 masked ch1", {31'd0, irq}, 0);
    sig_in[2] = 1'b0; idle(2); sig_in[2] = 1'b1;
    idle(5);
    check("R7 raise ch2", {31'd0, irq}, 1);
    wr(8'h54, 32'h0);
    idle(1);
    check("R7 drop on mask", {31'd0, irq}, 0);
    wr(8'h54, 32'h04);
    idle(1);
    check("R7 raise ch1 pending", {31'd0, irq}, 1);
    wr(8'h5C, 32'h1FF);
    idle(1);
    check("R7 drop on ack", {31'd0, irq}, 0);
    // R8 disabled: no capture
    rd(8'h18, v1);
    wr(8'h50, 32'h0);
    wr(8'h38, 32'd3);
    sig_in[2] = ~sig_in[2];
    idle(6);
    sig_in[2] = ~sig_in[2];
    idle(6);
    rd(8'h58, v); check("R8 no status when off", v, 0);
    rd(8'h18, v); check("R8 value kept when off", v, v1);
    check("R8 irq low when off", {31'd0, irq}, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule